// File: doc/BRIEF.md
# Granular-Page Address Translation Buffer

This block is a fully-associative translation buffer that turns virtual page numbers into physical page numbers. Each of its 128 slots can describe a single 8 KB base page or a naturally aligned run of 8, 64 or 512 base pages. The span is chosen by a 2-bit granularity hint stored with the slot. During the compare the hint hides the low page-number bits, and the same bits are carried from the virtual page number into the physical one. Every slot carries an 8-bit address space number, and a global bit that lets the slot match any space.

A table-walk agent writes new slots through the fill port. The fill lands on the slot named by a round-robin pointer, which moves on by one after each fill and wraps after the last slot. The lookup port takes a virtual address and the current space number. One clock later it returns hit, physical address, permission bits, a multi-hit flag and an address-error flag. Software can flush every slot at once, or only the non-global slots of one address space. The buffer does no table walking, no fault handling and no permission policy.

Top module: `gh_tlb`

## Requirements
- R1: After reset every slot is invalid, the replacement pointer is at slot 0 and `resp_valid` is low, so any lookup misses.
- R2: A lookup presented with `lk_valid` high in one cycle is answered in the next cycle, with `resp_valid` high for exactly that cycle.
- R3: With hint 0 (one 8 KB page), a slot hits only when all 35 virtual page number bits (`lk_va[47:13]`) equal its tag. The physical address is then the slot's 31-bit page number followed by `lk_va[12:0]`.
- R4: Hint g (0,1,2,3 for spans of 1, 8, 64, 512 pages) removes the lowest 3*g page-number bits from the compare. On a hit those bits of the physical page number are taken from the virtual page number and not from the slot.
- R5: A non-global slot hits only when its space number equals `lk_asn`. A global slot hits for any `lk_asn`.
- R6: Each fill writes the slot under the round-robin pointer and marks it valid. The pointer then moves on by one and wraps from 127 to 0, so the 129th fill after a full set overwrites the oldest slot. Invalidates do not move the pointer.
- R7: When several slots match, the lowest-index slot supplies the result and `resp_multi` is high. With one match, `resp_multi` is low.
- R8: With `va43_mode` high, a lookup whose `lk_va[47:43]` is not five copies of `lk_va[42]` returns `resp_hit`=0 and `resp_addr_err`=1. With `va43_mode` low no such check is made and all 35 page bits take part in the compare.
- R9: `inval_all` clears every valid bit in one cycle.
- R10: `inval_asn_en` clears only the slots that are non-global and whose space number equals `inval_asn`. All other slots keep their state.
- R11: Same-cycle ordering: a lookup sees the contents from before a fill in the same cycle. When a fill meets an invalidate in the same cycle, the invalidate applies first, so the filled slot remains valid.
- R12: On a hit, `resp_perm` returns the stored permission pair (bit 0 read, bit 1 write). On a miss, `resp_pa` and `resp_perm` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_va | input | 48 | Virtual address to translate |
| lk_asn | input | 8 | Current address space number |
| va43_mode | input | 1 | 1 = 43-bit virtual addressing with sign-extension check |
| fill_en | input | 1 | Write a new slot at the round-robin pointer |
| fill_vpn | input | 35 | Virtual page tag of the new slot |
| fill_ppn | input | 31 | Physical page number of the new slot |
| fill_hint | input | 2 | Granularity hint of the new slot |
| fill_asn | input | 8 | Address space number of the new slot |
| fill_global | input | 1 | Slot ignores the space number when set |
| fill_perm | input | 2 | Permission pair {write, read} |
| inval_all | input | 1 | Clear all valid bits |
| inval_asn_en | input | 1 | Clear non-global slots of one space |
| inval_asn | input | 8 | Space number for the selective clear |
| resp_valid | output | 1 | Response present (one cycle after request) |
| resp_hit | output | 1 | Translation found |
| resp_pa | output | 44 | Physical address |
| resp_perm | output | 2 | Permission pair of the winning slot |
| resp_multi | output | 1 | More than one slot matched |
| resp_addr_err | output | 1 | Non-canonical address in 43-bit mode |

## Verification
The two functions that can meet in one cycle are a lookup and a fill, and a fill and a flush. For the first, the bench raises `fill_en` and `lk_valid` on the same edge for the same page. It expects a miss that cycle and a hit on the following lookup. For the second, it pulses `fill_en` together with `inval_all`. It then checks that the earlier slots miss and the newly filled page still hits, which shows the flush was ordered before the write.

// File: rtl/gh_tlb_pkg.sv
package gh_tlb_pkg;
  // Each hint step widens the span by a factor of eight (three page bits).
  localparam int HINT_STEP = 3;

  typedef enum logic [1:0] {
    SPAN_1   = 2'd0,
    SPAN_8   = 2'd1,
    SPAN_64  = 2'd2,
    SPAN_512 = 2'd3
  } span_hint_e;

  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
endpackage

// File: rtl/gh_tlb_rr.sv
module gh_tlb_rr #(
  parameter int ENTRIES = 128,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (adv) ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv && ptr == IDX_W'(ENTRIES - 1)) |=> (ptr == '0)); // R6
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptr)); // R6
endmodule

// File: rtl/gh_tlb_cmp.sv
module gh_tlb_cmp
  import gh_tlb_pkg::*;
#(
  parameter int VPN_W = 35,
  parameter int ASN_W = 8
) (
  input  logic             ent_valid,
  input  logic [VPN_W-1:0] ent_tag,
  input  logic [1:0]       ent_hint,
  input  logic [ASN_W-1:0] ent_asn,
  input  logic             ent_global,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ASN_W-1:0] lk_asn,
  output logic             hit
);
  logic [VPN_W-1:0] care;
  logic             tag_ok;
  logic             asn_ok;

  always_comb begin
    care   = {VPN_W{1'b1}} << (HINT_STEP * int'(ent_hint));
    tag_ok = ((ent_tag ^ lk_vpn) & care) == '0;
    asn_ok = ent_global || (ent_asn == lk_asn);
    hit    = ent_valid && tag_ok && asn_ok;
  end
endmodule

// File: rtl/gh_tlb_pick.sv
module gh_tlb_pick #(
  parameter int ENTRIES = 128,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] hits,
  output logic [IDX_W-1:0]   idx,
  output logic               any,
  output logic               multi
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hits[i] && !any) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
    multi = |(hits & (hits - 1'b1));
  end

  always_comb begin
    AST_PICK_IS_HIT: assert (!any || hits[idx]); // R7
  end
endmodule

// File: rtl/gh_tlb.sv
module gh_tlb
  import gh_tlb_pkg::*;
#(
  parameter int ENTRIES    = 128,
  parameter int VA_W       = 48,
  parameter int SHORT_VA_W = 43,
  parameter int PA_W       = 44,
  parameter int PAGE_BITS  = 13,
  parameter int ASN_W      = 8,
  localparam int VPN_W     = VA_W - PAGE_BITS,
  localparam int PPN_W     = PA_W - PAGE_BITS,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_va,
  input  logic [ASN_W-1:0] lk_asn,
  input  logic             va43_mode,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [1:0]       fill_hint,
  input  logic [ASN_W-1:0] fill_asn,
  input  logic             fill_global,
  input  logic [1:0]       fill_perm,
  input  logic             inval_all,
  input  logic             inval_asn_en,
  input  logic [ASN_W-1:0] inval_asn,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic [PA_W-1:0]  resp_pa,
  output logic [1:0]       resp_perm,
  output logic             resp_multi,
  output logic             resp_addr_err
);
  // Slot payload: plain arrays written on fill, no reset (RAM-style).
  logic [VPN_W-1:0] tag_q  [ENTRIES];
  logic [PPN_W-1:0] ppn_q  [ENTRIES];
  logic [1:0]       hint_q [ENTRIES];
  logic [ASN_W-1:0] asn_q  [ENTRIES];
  logic             glb_q  [ENTRIES];
  logic [1:0]       perm_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, valid_nxt;

  logic [IDX_W-1:0]   ptr;
  logic [ENTRIES-1:0] hits;
  logic [IDX_W-1:0]   win;
  logic               any_hit, multi_hit;
  logic [VPN_W-1:0]   lk_vpn;
  logic               bad_va;
  logic [PPN_W-1:0]   low_keep;
  logic [PPN_W-1:0]   out_ppn;

  assign lk_vpn = lk_va[VA_W-1:PAGE_BITS];

  gh_tlb_rr #(.ENTRIES(ENTRIES)) u_rr (
    .clk(clk), .rst(rst), .adv(fill_en), .ptr(ptr)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    gh_tlb_cmp #(.VPN_W(VPN_W), .ASN_W(ASN_W)) u_cmp (
      .ent_valid (valid_q[e]),
      .ent_tag   (tag_q[e]),
      .ent_hint  (hint_q[e]),
      .ent_asn   (asn_q[e]),
      .ent_global(glb_q[e]),
      .lk_vpn    (lk_vpn),
      .lk_asn    (lk_asn),
      .hit       (hits[e])
    );
  end

  gh_tlb_pick #(.ENTRIES(ENTRIES)) u_pick (
    .hits(hits), .idx(win), .any(any_hit), .multi(multi_hit)
  );

  // Sign-extension check for the short address mode.
  always_comb begin
    bad_va = va43_mode &&
      (lk_va[VA_W-1:SHORT_VA_W] != {(VA_W - SHORT_VA_W){lk_va[SHORT_VA_W-1]}});
  end

  // Splice low page bits from the virtual page number per the winner's hint.
  always_comb begin
    low_keep = ~({PPN_W{1'b1}} << (HINT_STEP * int'(hint_q[win])));
    out_ppn  = (ppn_q[win] & ~low_keep) | (lk_vpn[PPN_W-1:0] & low_keep);
  end

  // Valid bits: invalidates first, fill last, so a same-cycle fill survives.
  always_comb begin
    valid_nxt = valid_q;
    if (inval_all) begin
      valid_nxt = '0;
    end else if (inval_asn_en) begin
      for (int i = 0; i < ENTRIES; i++)
        if (!glb_q[i] && asn_q[i] == inval_asn) valid_nxt[i] = 1'b0;
    end
    if (fill_en) valid_nxt[ptr] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else     valid_q <= valid_nxt;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[ptr]  <= fill_vpn;
      ppn_q[ptr]  <= fill_ppn;
      hint_q[ptr] <= fill_hint;
      asn_q[ptr]  <= fill_asn;
      glb_q[ptr]  <= fill_global;
      perm_q[ptr] <= fill_perm;
    end
  end

  // Registered response.
  logic take;
  assign take = lk_valid && any_hit && !bad_va;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid    <= 1'b0;
      resp_hit      <= 1'b0;
      resp_pa       <= '0;
      resp_perm     <= '0;
      resp_multi    <= 1'b0;
      resp_addr_err <= 1'b0;
    end else begin
      resp_valid    <= lk_valid;
      resp_hit      <= take;
      resp_pa       <= take ? {out_ppn, lk_va[PAGE_BITS-1:0]} : '0;
      resp_perm     <= take ? perm_q[win] : '0;
      resp_multi    <= take && multi_hit;
      resp_addr_err <= lk_valid && bad_va;
    end
  end

  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> resp_valid); // R2
  AST_IDLE_NO_RESP: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !resp_valid); // R2
  AST_ERR_BLOCKS_HIT: assert property (@(posedge clk) disable iff (rst)
    resp_addr_err |-> !resp_hit); // R8
  AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    resp_multi |-> resp_hit); // R7
  AST_MISS_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_hit) |-> (resp_pa == '0 && resp_perm == '0)); // R12
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (inval_all && !fill_en) |=> (valid_q == '0)); // R9
  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> valid_q[$past(ptr)]); // R6 R11
endmodule

// File: tb/gh_tlb_tb.sv
module gh_tlb_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [47:0] lk_va = '0;
  logic [7:0]  lk_asn = '0;
  logic        va43_mode = 1'b0;
  logic        fill_en = 1'b0;
  logic [34:0] fill_vpn = '0;
  logic [30:0] fill_ppn = '0;
  logic [1:0]  fill_hint = '0;
  logic [7:0]  fill_asn = '0;
  logic        fill_global = 1'b0;
  logic [1:0]  fill_perm = '0;
  logic        inval_all = 1'b0;
  logic        inval_asn_en = 1'b0;
  logic [7:0]  inval_asn = '0;
  logic        resp_valid, resp_hit, resp_multi, resp_addr_err;
  logic [43:0] resp_pa;
  logic [1:0]  resp_perm;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk; // 50 MHz

  gh_tlb u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va), .lk_asn(lk_asn),
    .va43_mode(va43_mode), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_hint(fill_hint), .fill_asn(fill_asn),
    .fill_global(fill_global), .fill_perm(fill_perm), .inval_all(inval_all),
    .inval_asn_en(inval_asn_en), .inval_asn(inval_asn),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_pa(resp_pa),
    .resp_perm(resp_perm), .resp_multi(resp_multi), .resp_addr_err(resp_addr_err)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [47:0] mkva(input logic [34:0] vpn, input logic [12:0] off);
    return {vpn, off};
  endfunction

  // One lookup; response sampled at the negedge after the capturing edge.
  task automatic look(input logic [47:0] va, input logic [7:0] asn, input bit m43,
                      input bit eh, input logic [43:0] epa, input logic [1:0] eperm,
                      input bit emul, input bit eerr, input string rq);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va; lk_asn = asn; va43_mode = m43;
    @(negedge clk);
    lk_valid = 1'b0; va43_mode = 1'b0;
    check(resp_valid === 1'b1, rq, "valid", 64'(resp_valid), 64'd1);
    check(resp_hit === eh, rq, "hit", 64'(resp_hit), 64'(eh));
    check(resp_pa === epa, rq, "pa", 64'(resp_pa), 64'(epa));
    check(resp_perm === eperm, rq, "perm", 64'(resp_perm), 64'(eperm));
    check(resp_multi === emul, rq, "multi", 64'(resp_multi), 64'(emul));
    check(resp_addr_err === eerr, rq, "addr_err", 64'(resp_addr_err), 64'(eerr));
  endtask

  task automatic fill(input logic [34:0] vpn, input logic [30:0] ppn, input logic [1:0] hint,
                      input logic [7:0] asn, input bit glb, input logic [1:0] perm);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_hint = hint;
    fill_asn = asn; fill_global = glb; fill_perm = perm;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk); inval_all = 1'b1;
    @(negedge clk); inval_all = 1'b0;
  endtask

  task automatic t_reset();
    check(resp_valid === 1'b0, "R1", "resp_valid after reset", 64'(resp_valid), 64'd0);
    look(48'h0, 8'd0, 1'b0, 1'b0, '0, 2'b00, 1'b0, 1'b0, "R1");
    look(mkva(35'h123, 13'h5), 8'd0, 1'b0, 1'b0, '0, 2'b00, 1'b0, 1'b0, "R1");
    @(negedge clk);
    check(resp_valid === 1'b0, "R2", "valid drops when idle", 64'(resp_valid), 64'd0);
  endtask

  task automatic t_base();
    fill(35'h0ABCD, 31'h1234, 2'd0, 8'd1, 1'b0, 2'b11);
    look(mkva(35'h0ABCD, 13'h1F0F), 8'd1, 1'b0, 1'b1, {31'h1234, 13'h1F0F}, 2'b11, 1'b0, 1'b0, "R3");
    look(mkva(35'h0ABCC, 13'h0), 8'd1, 1'b0, 1'b0, '0, 2'b00, 1'b0, 1'b0, "R3");
    look(mkva(35'h4_0000_ABCD, 13'h0), 8'd1, 1'b0, 1'b0, '0, 2'b00, 1'b0, 1'b0, "R12");
  endtask

  task automatic t_hints();
    flush();
    fill(35'h1000, 31'h2000, 2'd2, 8'd5, 1'b0, 2'b01);
    fill(35'h4000, 31'h7000, 2'd3, 8'd5, 1'b0, 2'b10);
    fill(35'h8008, 31'h9008, 2'd1, 8'd5, 1'b0, 2'b11);
    look(mkva(35'h1025, 13'h123), 8'd5, 1'b0, 1'b1, {31'h2025, 13'h123}, 2'b01, 1'b0, 1'b0, "R4");
    look(mkva(35'h1040, 13'h0), 8'd5, 1'b0, 1'b0, '0, 2'b00, 1'b0, 1'b0, "R4");
    look(mkva(35'h41FF, 13'h7), 8'd5, 1'b0, 1'b1, {31'h71FF, 13'h7}, 2'b10, 1'b0, 1'b0, "R4");
    look(mkva(35'h4200, 13'h0), 8'd5, 1'b0, 1'b0, '0, 2'b00, 1'b0, 1'b0, "R4");
    look(mkva(35'h800F, 13'h0), 8'd5, 1'b0, 1'b1, {31'h900F, 13'h0}, 2'b11, 1'b0, 1'b0, "R4");
    look(mkva(35'h8010, 13'h0), 8'd5, 1'b0, 1'b0, '0, 2'b00, 1'b0, 1'b0, "R4");
  endtask

  task automatic t_asn();
    flush();
    fill(35'h300, 31'h30, 2'd0, 8'd7, 1'b0, 2'b01);
    fill(35'h301, 31'h31, 2'd0, 8'd9, 1'b1, 2'b01);
    look(mkva(35'h300, 13'h0), 8'd7, 1'b0, 1'b1, {31'h30, 13'h0}, 2'b01, 1'b0, 1'b0, "R5");
    look(mkva(35'h300, 13'h0), 8'd8, 1'b0, 1'b0, '0, 2'b00, 1'b0, 1'b0, "R5");
    look(mkva(35'h301, 13'h0), 8'd200, 1'b0, 1'b1, {31'h31, 13'h0}, 2'b01, 1'b0, 1'b0, "R5");
  endtask

  task automatic t_multi();
    flush();
    fill(35'h500, 31'hA00, 2'd0, 8'd2, 1'b0, 2'b01);
    fill(35'h500, 31'hB00, 2'd1, 8'd2, 1'b0, 2'b11);
    look(mkva(35'h500, 13'h4), 8'd2, 1'b0, 1'b1, {31'hA00, 13'h4}, 2'b01, 1'b1, 1'b0, "R7");
    look(mkva(35'h503, 13'h4), 8'd2, 1'b0, 1'b1, {31'hB03, 13'h4}, 2'b11, 1'b0, 1'b0, "R7");
  endtask

  task automatic t_va43();
    flush();
    fill(35'h4_0000_0001, 31'h55, 2'd0, 8'd1, 1'b0, 2'b01);
    fill(35'h7_FFFF_FFFF, 31'h66, 2'd0, 8'd1, 1'b0, 2'b10);
    look(48'h8000_0000_2000, 8'd1, 1'b0, 1'b1, {31'h55, 13'h0}, 2'b01, 1'b0, 1'b0, "R8");
    look(48'h8000_0000_2000, 8'd1, 1'b1, 1'b0, '0, 2'b00, 1'b0, 1'b1, "R8");
    look(48'hFFFF_FFFF_E001, 8'd1, 1'b1, 1'b1, {31'h66, 13'h1}, 2'b10, 1'b0, 1'b0, "R8");
  endtask

  task automatic t_inval();
    flush();
    fill(35'h600, 31'h60, 2'd0, 8'd3, 1'b0, 2'b01);
    fill(35'h601, 31'h61, 2'd0, 8'd3, 1'b1, 2'b01);
    fill(35'h602, 31'h62, 2'd0, 8'd4, 1'b0, 2'b01);
    @(negedge clk); inval_asn_en = 1'b1; inval_asn = 8'd3;
    @(negedge clk); inval_asn_en = 1'b0;
    look(mkva(35'h600, 13'h0), 8'd3, 1'b0, 1'b0, '0, 2'b00, 1'b0, 1'b0, "R10");
    look(mkva(35'h601, 13'h0), 8'd3, 1'b0, 1'b1, {31'h61, 13'h0}, 2'b01, 1'b0, 1'b0, "R10");
    look(mkva(35'h602, 13'h0), 8'd4, 1'b0, 1'b1, {31'h62, 13'h0}, 2'b01, 1'b0, 1'b0, "R10");
    flush();
    look(mkva(35'h601, 13'h0), 8'd3, 1'b0, 1'b0, '0, 2'b00, 1'b0, 1'b0, "R9");
    look(mkva(35'h602, 13'h0), 8'd4, 1'b0, 1'b0, '0, 2'b00, 1'b0, 1'b0, "R9");
  endtask

  task automatic t_same_cycle();
    flush();
    fill(35'h700, 31'h70, 2'd0, 8'd1, 1'b0, 2'b01);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = 35'h710; fill_ppn = 31'h71; fill_hint = 2'd0;
    fill_asn = 8'd1; fill_global = 1'b0; fill_perm = 2'b11;
    lk_valid = 1'b1; lk_va = mkva(35'h710, 13'h0); lk_asn = 8'd1;
    @(negedge clk);
    fill_en = 1'b0; lk_valid = 1'b0;
    check(resp_hit === 1'b0, "R11", "lookup with fill sees old state", 64'(resp_hit), 64'd0);
    look(mkva(35'h710, 13'h0), 8'd1, 1'b0, 1'b1, {31'h71, 13'h0}, 2'b11, 1'b0, 1'b0, "R11");
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = 35'h720; fill_ppn = 31'h72; inval_all = 1'b1;
    @(negedge clk);
    fill_en = 1'b0; inval_all = 1'b0;
    look(mkva(35'h700, 13'h0), 8'd1, 1'b0, 1'b0, '0, 2'b00, 1'b0, 1'b0, "R11");
    look(mkva(35'h710, 13'h0), 8'd1, 1'b0, 1'b0, '0, 2'b00, 1'b0, 1'b0, "R11");
    look(mkva(35'h720, 13'h0), 8'd1, 1'b0, 1'b1, {31'h72, 13'h0}, 2'b11, 1'b0, 1'b0, "R11");
  endtask

  task automatic t_round_robin();
    flush();
    for (int i = 0; i < 128; i++)
      fill(35'h10000 + 35'(i), 31'h400 + 31'(i), 2'd0, 8'd6, 1'b0, 2'b01);
    look(mkva(35'h10000, 13'h0), 8'd6, 1'b0, 1'b1, {31'h400, 13'h0}, 2'b01, 1'b0, 1'b0, "R6");
    look(mkva(35'h1007F, 13'h0), 8'd6, 1'b0, 1'b1, {31'h47F, 13'h0}, 2'b01, 1'b0, 1'b0, "R6");
    fill(35'h20000, 31'h800, 2'd0, 8'd6, 1'b0, 2'b10);
    look(mkva(35'h10000, 13'h0), 8'd6, 1'b0, 1'b0, '0, 2'b00, 1'b0, 1'b0, "R6");
    look(mkva(35'h10001, 13'h0), 8'd6, 1'b0, 1'b1, {31'h401, 13'h0}, 2'b01, 1'b0, 1'b0, "R6");
    look(mkva(35'h20000, 13'h0), 8'd6, 1'b0, 1'b1, {31'h800, 13'h0}, 2'b10, 1'b0, 1'b0, "R6");
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_base();
    t_hints();
    t_asn();
    t_multi();
    t_va43();
    t_inval();
    t_same_cycle();
    t_round_robin();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule